// File: doc/BRIEF.md
# Multi-lane 1:7 display link deserializer

This block turns serial display-link lanes back into parallel pixel words. Each serial lane delivers seven bits per pixel period. A separate forwarded-clock lane repeats a fixed seven-bit shape once per word. All lanes are sampled on a supplied bit clock that runs at seven times the pixel rate. The block finds the word boundary by locating that shape. It then assembles a 28-bit word from four lanes and produces a recovered pixel clock. Each new word appears on the rising edge of that clock.

A narrow mode uses only the lower three lanes and yields 21 bits. If framing is lost, the last good word stays on the output and the pixel clock is held low. Framing is lost when the boundary shape fails or the clock lane stops toggling. An active-low power-down clears the block and drives the outputs low. After power-down is released, or after any loss, the outputs stay inactive until a run of good boundaries has been seen.

Top module: `dlr_deser`

## Requirements
- R1: Lane k carries word bits 7k+6 down to 7k, most significant bit first in time. In wide mode, word_o[7k+6:7k] holds the seven bits of lane k.
- R2: The forwarded-clock lane carries 1100011 once per word, with the leftmost bit first in time. The block tries every one of the seven bit offsets. It places the word boundary at the bit where that shape completes.
- R3: After power-down is released, locked_o rises at the boundary of the LOCK_WORDS-th consecutive matching word. Until then word_o is 0, and pclk_o and locked_o are 0.
- R4: Word n appears on word_o at the bit-clock edge that completes word n+1. That is seven bit periods after its own last bit. pclk_o rises at that same edge, and word_o never changes without such a rise.
- R5: While locked, pclk_o has a seven-bit-period cycle: high for four bit periods, then low for three.
- R6: A boundary where the clock-lane shape does not match drops locked_o. So does a clock lane with no transition for LOSS_BITS bit periods. Once dropped, pclk_o is forced low and word_o holds its last value.
- R7: While pwr_dn_ni is low, each bit-clock edge clears the framing state and drives word_o, pclk_o and locked_o to 0.
- R8: With narrow_i at 1, lane 3 is ignored and word_o[27:21] is 0. Bits 20:0 follow R1. narrow_i may change only during power-down.
- R9: After a loss, the block must see LOCK_WORDS new consecutive matching words before it locks again. It then shows words per R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_ni | input | 1 | Power-down, active low, acts at the clock edge |
| narrow_i | input | 1 | 1 selects three-lane, 21-bit operation |
| lane_i | input | LANES | Serial data lanes, one bit per bit clock |
| fclk_i | input | 1 | Forwarded-clock lane, sampled like data |
| word_o | output | 7*LANES | Rebuilt parallel word |
| pclk_o | output | 1 | Recovered pixel clock |
| locked_o | output | 1 | Framing lock achieved |

## Verification
The checks assume that the lanes are already sampled into the bit-clock domain, one bit per edge, with no skew between lanes. They also assume that narrow_i changes only while pwr_dn_ni is low, since the word pipeline spans two boundaries. The bench drives every lane and the clock lane on the falling edge from one serializer model, so all bits of a word share one alignment. It switches modes only inside a power-down pulse. Losses are made either by a corrupt boundary shape or by holding the clock lane steady well past LOSS_BITS.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  localparam int unsigned SER_RATIO = 7;
  localparam logic [SER_RATIO-1:0] FRAME_MARK = 7'b1100011;
  localparam int unsigned PH_W = $clog2(SER_RATIO);
endpackage

// File: rtl/dlr_lane_shift.sv
module dlr_lane_shift import dlr_pkg::*; #(
  parameter int unsigned W = SER_RATIO
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);
  logic [W-2:0] sr_q;

  // window includes the bit arriving at this edge
  assign win_o = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (clr_i) sr_q <= '0;
    else            sr_q <= win_o[W-2:0];
  end
endmodule

// File: rtl/dlr_framer.sv
module dlr_framer import dlr_pkg::*; #(
  parameter int unsigned LOCK_WORDS = 4,
  parameter int unsigned LOSS_BITS  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic [SER_RATIO-1:0] mark_win_i,
  output logic                 take_o,
  output logic                 show_o,
  output logic                 pclk_o,
  output logic                 locked_o
);
  localparam int unsigned HIT_W  = $clog2(LOCK_WORDS + 1);
  localparam int unsigned IDLE_W = $clog2(LOSS_BITS + 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SER_RATIO - 1);
  localparam logic [PH_W-1:0] HIGH_PH = PH_W'((SER_RATIO - 1) / 2);

  logic [PH_W-1:0]   ph_q, ph_d;
  logic [HIT_W-1:0]  hits_q, hits_d;
  logic [IDLE_W-1:0] idle_q;
  logic at_edge, hit, lost, toggled, lock_d, lock_q, pclk_q;

  assign at_edge = (ph_q == LAST_PH);
  assign hit     = at_edge && (mark_win_i == FRAME_MARK);
  assign lost    = (idle_q >= IDLE_W'(LOSS_BITS));
  assign toggled = mark_win_i[0] ^ mark_win_i[1];

  always_comb begin
    // a miss keeps the phase on the last slot: each later bit is a new offset
    if (at_edge) ph_d = hit ? '0 : LAST_PH;
    else         ph_d = ph_q + PH_W'(1);

    hits_d = hits_q;
    if (lost)         hits_d = '0;
    else if (at_edge) begin
      if (!hit)                                hits_d = '0;
      else if (hits_q != HIT_W'(LOCK_WORDS))   hits_d = hits_q + HIT_W'(1);
    end
    lock_d = (hits_d == HIT_W'(LOCK_WORDS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= LAST_PH; hits_q <= '0; idle_q <= '0; lock_q <= 1'b0; pclk_q <= 1'b0;
    end else if (clr_i) begin
      ph_q <= LAST_PH; hits_q <= '0; idle_q <= '0; lock_q <= 1'b0; pclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      hits_q <= hits_d;
      if (toggled)   idle_q <= '0;
      else if (!lost) idle_q <= idle_q + IDLE_W'(1);
      lock_q <= lock_d;
      pclk_q <= lock_d && (ph_d <= HIGH_PH);
    end
  end

  assign take_o   = hit;
  assign show_o   = hit && lock_d;
  assign pclk_o   = pclk_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/dlr_word_out.sv
module dlr_word_out #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              show_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] cap_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0; out_q <= '0;
    end else if (clr_i) begin
      cap_q <= '0; out_q <= '0;
    end else begin
      if (take_i) cap_q <= word_i;
      if (show_i) out_q <= cap_q;
    end
  end

  assign word_o = out_q;
endmodule

// File: rtl/dlr_deser.sv
module dlr_deser import dlr_pkg::*; #(
  parameter int unsigned LANES      = 4,
  parameter int unsigned LOCK_WORDS = 4,
  parameter int unsigned LOSS_BITS  = 16,
  localparam int unsigned WORD_W    = LANES * SER_RATIO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_dn_ni,
  input  logic              narrow_i,
  input  logic [LANES-1:0]  lane_i,
  input  logic              fclk_i,
  output logic [WORD_W-1:0] word_o,
  output logic              pclk_o,
  output logic              locked_o
);
  logic                 clr, take, show;
  logic [SER_RATIO-1:0] mark_win;
  logic [WORD_W-1:0]    asm_word;

  assign clr = ~pwr_dn_ni;

  dlr_lane_shift #(.W(SER_RATIO)) u_mark (
    .clk_i, .rst_ni, .clr_i(clr), .bit_i(fclk_i), .win_o(mark_win)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SER_RATIO-1:0] win;
    dlr_lane_shift #(.W(SER_RATIO)) u_shift (
      .clk_i, .rst_ni, .clr_i(clr), .bit_i(lane_i[k]), .win_o(win)
    );
    if (k == LANES - 1) begin : g_top
      assign asm_word[k*SER_RATIO +: SER_RATIO] = narrow_i ? '0 : win;
    end else begin : g_low
      assign asm_word[k*SER_RATIO +: SER_RATIO] = win;
    end
  end

  dlr_framer #(.LOCK_WORDS(LOCK_WORDS), .LOSS_BITS(LOSS_BITS)) u_framer (
    .clk_i, .rst_ni, .clr_i(clr), .mark_win_i(mark_win),
    .take_o(take), .show_o(show), .pclk_o, .locked_o
  );

  dlr_word_out #(.WORD_W(WORD_W)) u_out (
    .clk_i, .rst_ni, .clr_i(clr), .take_i(take), .show_i(show),
    .word_i(asm_word), .word_o
  );
endmodule

// File: rtl/dlr_deser_chk.sv
module dlr_deser_chk import dlr_pkg::*; #(
  parameter int unsigned WORD_W    = 28,
  parameter int unsigned LOSS_BITS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_dn_ni,
  input logic              narrow_i,
  input logic              fclk_i,
  input logic [WORD_W-1:0] word_o,
  input logic              pclk_o,
  input logic              locked_o
);
  localparam int unsigned Q_MAX = LOSS_BITS + 2;
  localparam int unsigned Q_W   = $clog2(Q_MAX + 1);

  logic           fclk_prev_q;
  logic [Q_W-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_prev_q <= 1'b0; quiet_q <= '0;
    end else begin
      fclk_prev_q <= fclk_i;
      if (!pwr_dn_ni || fclk_i != fclk_prev_q) quiet_q <= '0;
      else if (quiet_q != Q_W'(Q_MAX))         quiet_q <= quiet_q + Q_W'(1);
    end
  end

  a_r7_pd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |=> (word_o == '0 && !pclk_o && !locked_o));

  a_r4_word_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_dn_ni && $past(pwr_dn_ni) && !$stable(word_o)) |-> ($rose(pclk_o) && locked_o));

  a_r8_narrow_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_i && $past(narrow_i) && $past(pwr_dn_ni) && !$stable(word_o))
      |-> (word_o[WORD_W-1 -: SER_RATIO] == '0));

  a_r6_quiet_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q == Q_W'(Q_MAX)) |-> !locked_o);

  a_r5_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pclk_o) && locked_o) |=> (!pclk_o || !locked_o));

  a_r5_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pclk_o) && pwr_dn_ni) |=> (pclk_o || !locked_o || !$past(pwr_dn_ni) || !pwr_dn_ni));
endmodule

bind dlr_deser dlr_deser_chk #(.WORD_W(WORD_W), .LOSS_BITS(LOSS_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_dn_ni(pwr_dn_ni), .narrow_i(narrow_i),
  .fclk_i(fclk_i), .word_o(word_o), .pclk_o(pclk_o), .locked_o(locked_o)
);

// File: tb/dlr_deser_bench.sv
module dlr_deser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int LOCK_WORDS = 4;
  localparam int LOSS_BITS  = 16;
  localparam int WORD_W     = LANES * 7;
  localparam logic [6:0] MARK = 7'b1100011;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pwr_dn_ni = 1'b1;
  logic              narrow_i = 1'b0;
  logic [LANES-1:0]  lane_i = '0;
  logic              fclk_i = 1'b1;
  logic [WORD_W-1:0] word_o;
  logic              pclk_o, locked_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [6:0]        shape;
  logic [WORD_W-1:0] last_shown;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlr_deser #(.LANES(LANES), .LOCK_WORDS(LOCK_WORDS), .LOSS_BITS(LOSS_BITS)) u_dlr_deser (
    .clk_i(clk), .rst_ni, .pwr_dn_ni, .narrow_i, .lane_i, .fclk_i,
    .word_o, .pclk_o, .locked_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] pat_word(input int i);
    logic [31:0] x;
    x = (32'(i) + 32'd1) * 32'h9E3779B1;
    return x[WORD_W-1:0] ^ 28'h5A53C3C;
  endfunction

  function automatic logic [WORD_W-1:0] masked(input logic [WORD_W-1:0] w, input logic nar);
    return nar ? {7'b0, w[WORD_W-8:0]} : w;
  endfunction

  // serializer model: lane k sends bit 7k+6 first
  task automatic send_frame(input logic [WORD_W-1:0] w, input logic [6:0] mark);
    for (int t = 0; t < 7; t++) begin
      @(negedge clk);
      for (int k = 0; k < LANES; k++) lane_i[k] = w[7*k + 6 - t];
      fclk_i = mark[6 - t];
      @(posedge clk);
      #(CLK_PERIOD/4);
      shape[6 - t] = pclk_o;
    end
  endtask

  task automatic power_cycle(input logic nar);
    @(negedge clk); pwr_dn_ni = 1'b0; narrow_i = nar;
    @(negedge clk); pwr_dn_ni = 1'b1;
  endtask

  // frames base..base+n-1; before lock outputs must stay at hold
  task automatic lock_run(input string req, input int base, input int n, input logic nar,
                          input logic [WORD_W-1:0] hold);
    for (int i = 0; i < n; i++) begin
      send_frame(pat_word(base + i), MARK);
      if (i < LOCK_WORDS - 1) begin
        chk(req, "locked before run", 32'(locked_o), 32'd0);
        chk(req, "pclk before run", 32'(pclk_o), 32'd0);
        chk(req, "word held before run", 32'(word_o), 32'(hold));
      end else begin
        chk(req, "locked", 32'(locked_o), 32'd1);
        chk("R4", "pclk rises with word", 32'(pclk_o), 32'd1);
        chk("R1", "word lags one frame", 32'(word_o), 32'(masked(pat_word(base + i - 1), nar)));
        if (i >= LOCK_WORDS) chk("R5", "pclk shape", 32'(shape), 32'b1110001);
      end
    end
    last_shown = word_o;
  endtask

  task automatic test_reset();
    chk("R3", "reset word", 32'(word_o), 32'd0);
    chk("R3", "reset pclk", 32'(pclk_o), 32'd0);
    chk("R3", "reset locked", 32'(locked_o), 32'd0);
  endtask

  task automatic test_wide_lock();
    power_cycle(1'b0);
    lock_run("R3", 0, 8, 1'b0, '0);
  endtask

  task automatic test_bad_mark();
    logic [WORD_W-1:0] keep;
    keep = last_shown;
    send_frame(pat_word(100), 7'b0000000);
    chk("R6", "bad mark unlocks", 32'(locked_o), 32'd0);
    chk("R6", "bad mark pclk low", 32'(pclk_o), 32'd0);
    chk("R6", "bad mark holds word", 32'(word_o), 32'(keep));
    lock_run("R9", 200, 5, 1'b0, keep);
  endtask

  task automatic test_loss();
    logic [WORD_W-1:0] keep;
    keep = last_shown;
    for (int c = 0; c < LOSS_BITS + 8; c++) begin
      @(negedge clk);
      lane_i = LANES'(c * 5 + 3);
      fclk_i = 1'b1;
    end
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R6", "loss unlocks", 32'(locked_o), 32'd0);
    chk("R6", "loss pclk low", 32'(pclk_o), 32'd0);
    chk("R6", "loss holds word", 32'(word_o), 32'(keep));
    lock_run("R9", 300, 5, 1'b0, keep);
  endtask

  task automatic test_pd();
    @(negedge clk); pwr_dn_ni = 1'b0;
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R7", "pd word", 32'(word_o), 32'd0);
    chk("R7", "pd pclk", 32'(pclk_o), 32'd0);
    chk("R7", "pd locked", 32'(locked_o), 32'd0);
    for (int f = 0; f < 2; f++) begin
      send_frame(pat_word(350 + f), MARK);
      chk("R7", "pd holds word low", 32'(word_o), 32'd0);
      chk("R7", "pd holds pclk low", 32'(pclk_o), 32'd0);
    end
    @(negedge clk); pwr_dn_ni = 1'b1;
    lock_run("R3", 400, 5, 1'b0, '0);
  endtask

  task automatic test_narrow();
    power_cycle(1'b1);
    lock_run("R8", 500, 6, 1'b1, '0);
    chk("R8", "top lane ignored", 32'(word_o[WORD_W-1 -: 7]), 32'd0);
    power_cycle(1'b0);
    lock_run("R2", 600, 5, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + CLK_PERIOD/4);
    test_reset();
    @(negedge clk); rst_ni = 1'b1;
    test_wide_lock();
    test_bad_mark();
    test_loss();
    test_pd();
    test_narrow();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule